// File: doc/BRIEF.md
# Programmable CRC-32 Accelerator

This block computes a 32-bit cyclic redundancy check for software over a small register bus. Software stores a starting value and a generator polynomial in two registers. It then writes a control word whose bit 0 is set, which seeds the running checksum. After that, every 32-bit word written to the data location is folded into the checksum in a single clock. Reading the data location returns the checksum so far. Software applies any final inversion itself.

The polynomial is held in normal, most-significant-bit-first form. A three-bit mode field in the control word turns on bit reversal. When all three bits are set, each incoming word is mirrored before it is folded and the checksum is mirrored when it is read. This makes the reflected CRC-32 and CRC-32C conventions available on the same datapath. The polynomial and the starting value are copied into the datapath only when the seed pulse arrives. Software can therefore prepare the next computation while the current one is still running.

Top module: `crc_engine`

## Requirements
- R1: After reset, the initial-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data location reads 0xFFFFFFFF.
- R2: Word addresses 4 (byte 0x10) and 5 (byte 0x14) hold the initial value and the polynomial. A write to either is returned in full by a later read.
- R3: The control register is at word address 2 (byte 0x08). Bits 7:5 are the mode field and read back as written. Bit 0 and every other bit read as 0.
- R4: Writing the control register with bit 0 set loads the running checksum from the initial-value register and latches the polynomial register into the datapath. A read of word address 0 in the next cycle returns that value, mirrored when the mode field is 3'b111.
- R5: A write to word address 0 (byte 0x00) folds all 32 data bits into the checksum, most significant bit first. For each bit, the checksum shifts left, and the latched polynomial is XORed in when the old top bit differs from the data bit. A read in the next cycle returns the result.
- R6: With mode field 3'b111, each data word is bit-mirrored before folding and the read value is bit-mirrored. This equals the reflected, LSB-first CRC using the mirrored polynomial.
- R7: Any mode value other than 3'b111 leaves both input and output unmirrored.
- R8: Writing the initial-value or polynomial register leaves the running checksum unchanged. The new values take effect only from the next seed pulse.
- R9: Writes to word addresses other than 0, 2, 4 and 5 change nothing. Reads there return 0. The read data is 0 in every cycle where the read strobe is low.
- R10: Seeding with 0xFFFFFFFF and the CRC-32 polynomial in mirrored mode, then folding the word 0x00000000, reads 0xDEBB20E3. This is the bitwise complement of the standard CRC-32 of four zero bytes.
- R11: Data words written in consecutive cycles are each folded, with no lost word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Word address (byte offset divided by 4) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, 0 when no read is in progress |

## Verification
The bench uses the default parameters: a 32-bit checksum and a 4-bit word address. With a 4-bit address, all sixteen locations can be visited, so every unmapped location is tried for both write and read. The sweep covers all eight mode values against four different polynomials. Each step is compared with two independent reference computations. For unmirrored modes, the reference is a 64-bit polynomial remainder. For the mirrored mode, it is an LSB-first shift-right loop. The bench also checks one published CRC-32 residue value.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 2;
  localparam int unsigned OFS_INIT = 4;
  localparam int unsigned OFS_POLY = 5;
  localparam int unsigned CTRL_SEED_BIT = 0;
  localparam int unsigned MODE_LO = 5;
  localparam int unsigned MODE_W = 3;

  typedef struct packed {
    logic seed;
    logic fold;
    logic mirrorIn;
    logic mirrorOut;
  } crcStrobe_t;
endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign dout[g] = din[W-1-g];
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_INIT = '1,
  parameter logic [W-1:0] RST_POLY = 32'h04C11DB7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  crc_eng_pkg::crcStrobe_t  strobe,
  input  logic [W-1:0]             wordIn,
  input  logic [W-1:0]             initVal,
  input  logic [W-1:0]             polyVal,
  output logic [W-1:0]             crcRaw,
  output logic [W-1:0]             activePoly,
  output logic [W-1:0]             crcView
);
  logic [W-1:0] wordRev;
  logic [W-1:0] wordEff;
  logic [W-1:0] crcRev;
  logic [W-1:0] nextCrc;

  crc_bitrev #(.W(W)) i_revIn  (.din(wordIn), .dout(wordRev));
  crc_bitrev #(.W(W)) i_revOut (.din(crcRaw), .dout(crcRev));

  assign wordEff = strobe.mirrorIn ? wordRev : wordIn;
  assign crcView = strobe.mirrorOut ? crcRev : crcRaw;

  // Unrolled shift-and-XOR, MSB of the word first
  always_comb begin
    logic [W-1:0] acc;
    logic fb;
    acc = crcRaw;
    for (int i = W - 1; i >= 0; i--) begin
      fb  = acc[W-1] ^ wordEff[i];
      acc = {acc[W-2:0], 1'b0} ^ (fb ? activePoly : '0);
    end
    nextCrc = acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcRaw     <= RST_INIT;
      activePoly <= RST_POLY;
    end else if (strobe.seed) begin
      crcRaw     <= initVal;
      activePoly <= polyVal;
    end else if (strobe.fold) begin
      crcRaw     <= nextCrc;
    end
  end
endmodule

// File: rtl/crc_regs.sv
module crc_regs #(
  parameter int unsigned W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [W-1:0] RST_INIT = '1,
  parameter logic [W-1:0] RST_POLY = 32'h04C11DB7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [W-1:0]             wrData,
  input  logic [W-1:0]             crcView,
  output crc_eng_pkg::crcStrobe_t  strobe,
  output logic [W-1:0]             initReg,
  output logic [W-1:0]             polyReg,
  output logic [W-1:0]             rdData
);
  import crc_eng_pkg::*;

  localparam int unsigned MODE_HI = MODE_LO + MODE_W - 1;
  localparam int unsigned PAD_W = W - MODE_HI - 1;

  logic [MODE_W-1:0] modeReg;
  logic hitData, hitCtrl, hitInit, hitPoly;
  logic mirrorOn;

  assign hitData = (addr == ADDR_W'(OFS_DATA));
  assign hitCtrl = (addr == ADDR_W'(OFS_CTRL));
  assign hitInit = (addr == ADDR_W'(OFS_INIT));
  assign hitPoly = (addr == ADDR_W'(OFS_POLY));
  assign mirrorOn = &modeReg;

  always_comb begin
    strobe.seed      = wrEn && hitCtrl && wrData[CTRL_SEED_BIT];
    strobe.fold      = wrEn && hitData;
    strobe.mirrorIn  = mirrorOn;
    strobe.mirrorOut = mirrorOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReg <= RST_INIT;
      polyReg <= RST_POLY;
      modeReg <= '0;
    end else if (wrEn) begin
      if (hitInit) initReg <= wrData;
      if (hitPoly) polyReg <= wrData;
      if (hitCtrl) modeReg <= wrData[MODE_HI:MODE_LO];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (hitData)      rdData = crcView;
      else if (hitCtrl) rdData = {{PAD_W{1'b0}}, modeReg, {MODE_LO{1'b0}}};
      else if (hitInit) rdData = initReg;
      else if (hitPoly) rdData = polyReg;
    end
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int unsigned W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [W-1:0] RST_INIT = '1,
  parameter logic [W-1:0] RST_POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData
);
  crc_eng_pkg::crcStrobe_t strobe;
  logic [W-1:0] initReg, polyReg;
  logic [W-1:0] crcRaw, activePoly, crcView;

  crc_regs #(.W(W), .ADDR_W(ADDR_W), .RST_INIT(RST_INIT), .RST_POLY(RST_POLY)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .crcView(crcView), .strobe(strobe), .initReg(initReg), .polyReg(polyReg),
    .rdData(rdData)
  );

  crc_datapath #(.W(W), .RST_INIT(RST_INIT), .RST_POLY(RST_POLY)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(wrData), .initVal(initReg),
    .polyVal(polyReg), .crcRaw(crcRaw), .activePoly(activePoly), .crcView(crcView)
  );
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrBit0,
  input logic [W-1:0]      rdData,
  input logic              seedStb,
  input logic              foldStb,
  input logic [W-1:0]      crcRaw,
  input logic [W-1:0]      activePoly,
  input logic [W-1:0]      initReg,
  input logic [W-1:0]      polyReg
);
  import crc_eng_pkg::*;

  logic unmapped;
  assign unmapped = (addr != ADDR_W'(OFS_DATA)) && (addr != ADDR_W'(OFS_CTRL)) &&
                    (addr != ADDR_W'(OFS_INIT)) && (addr != ADDR_W'(OFS_POLY));

  // R4: a seed write at the ports loads the initial value
  p_seed_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_CTRL) && wrBit0) |=> (crcRaw == $past(initReg)));

  // R8: the polynomial used by the datapath moves only on a seed
  p_poly_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seedStb |=> $stable(activePoly));

  // R8: the checksum holds when neither seed nor fold occurs
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!seedStb && !foldStb) |=> $stable(crcRaw));

  // R3: reserved control bits and the seed bit read as zero
  p_ctrl_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFS_CTRL)) |-> (rdData[4:0] == '0 && rdData[W-1:8] == '0));

  // R9: unmapped reads and idle cycles return zero
  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || unmapped) |-> (rdData == '0));

  // R9: unmapped writes cause no seed or fold
  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && unmapped) |-> (!seedStb && !foldStb));

  // R8: a seed latches the polynomial register
  p_poly_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    seedStb |=> (activePoly == $past(polyReg)));
endmodule

bind crc_engine crc_engine_chk #(.W(W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrBit0(wrData[0]),
  .rdData(rdData), .seedStb(strobe.seed), .foldStb(strobe.fold), .crcRaw(crcRaw),
  .activePoly(activePoly), .initReg(initReg), .polyReg(polyReg)
);

// File: tb/test_crc_engine.sv
`timescale 1ns/1ps
module test_crc_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crc_engine i_crc_engine (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
                           .addr(addr), .wrData(wrData), .rdData(rdData));

  function automatic logic [31:0] mirror(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // Remainder of ((crc ^ d) * x^32) modulo (x^32 + poly)
  function automatic logic [31:0] refNorm(input logic [31:0] crc, input logic [31:0] d,
                                          input logic [31:0] poly);
    logic [63:0] v;
    v = {crc ^ d, 32'h0};
    for (int b = 63; b >= 32; b--)
      if (v[b]) v = v ^ ({31'h0, 1'b1, poly} << (b - 32));
    return v[31:0];
  endfunction

  // Reflected LSB-first update with mirrored polynomial
  function automatic logic [31:0] refRefl(input logic [31:0] r, input logic [31:0] d,
                                          input logic [31:0] rpoly);
    logic [31:0] s;
    s = r;
    for (int i = 0; i < 32; i++) begin
      if (s[0] ^ d[i]) s = (s >> 1) ^ rpoly;
      else s = s >> 1;
    end
    return s;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdData, exp);
    end
    rdEn = 1'b0;
  endtask

  logic [31:0] polys [4] = '{32'h04C11DB7, 32'h1EDC6F41, 32'h814141AB, 32'h000000AF};
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(4'd4, 32'hFFFFFFFF, "R1");
    check(4'd5, 32'h04C11DB7, "R1");
    check(4'd2, 32'h0, "R1");
    check(4'd0, 32'hFFFFFFFF, "R1");

    // R10 published residue
    wr(4'd2, 32'h000000E1);
    check(4'd0, 32'hFFFFFFFF, "R10");
    wr(4'd0, 32'h0);
    check(4'd0, 32'hDEBB20E3, "R10");

    // R3 control bits other than mode read zero
    wr(4'd2, 32'hFFFFFFFF);
    check(4'd2, 32'h000000E0, "R3");

    // Sweep: polynomials x modes
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] iv;
        iv = lfsr ^ 32'h5A5A0F0F;
        lfsr = step(lfsr);
        wr(4'd4, iv);
        check(4'd4, iv, "R2");
        wr(4'd5, polys[p]);
        check(4'd5, polys[p], "R2");
        wr(4'd2, 32'(m) << 5 | 32'h1);
        check(4'd2, 32'(m) << 5, "R3");
        exp = (m == 7) ? mirror(iv) : iv;
        check(4'd0, exp, "R4");
        for (int k = 0; k < 6; k++) begin
          wr(4'd0, lfsr);
          if (m == 7) exp = refRefl(exp, lfsr, mirror(polys[p]));
          else exp = refNorm(exp, lfsr, polys[p]);
          lfsr = step(lfsr);
          check(4'd0, exp, (m == 7) ? "R6" : ((m == 0) ? "R5" : "R7"));
        end
      end
    end

    // R11 back-to-back words, mode 0, CRC-32 polynomial
    wr(4'd5, 32'h04C11DB7);
    wr(4'd4, 32'h12345678);
    wr(4'd2, 32'h1);
    exp = 32'h12345678;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      wrEn = 1'b1; addr = 4'd0; wrData = lfsr;
      exp = refNorm(exp, lfsr, 32'h04C11DB7);
      lfsr = step(lfsr);
      @(negedge clk);
    end
    wrEn = 1'b0;
    check(4'd0, exp, "R11");

    // R8 new init and poly wait for a seed
    wr(4'd4, 32'hCAFEF00D);
    wr(4'd5, 32'h1EDC6F41);
    check(4'd0, exp, "R8");
    wr(4'd0, 32'h0BADBEEF);
    exp = refNorm(exp, 32'h0BADBEEF, 32'h04C11DB7);
    check(4'd0, exp, "R8");
    wr(4'd2, 32'h1);
    check(4'd0, 32'hCAFEF00D, "R8");
    wr(4'd0, 32'h0BADBEEF);
    exp = refNorm(32'hCAFEF00D, 32'h0BADBEEF, 32'h1EDC6F41);
    check(4'd0, exp, "R8");

    // R9 unmapped addresses
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 4 && a != 5) begin
        wr(4'(a), 32'hA5A5A5A5);
        check(4'(a), 32'h0, "R9");
        check(4'd0, exp, "R9");
      end
    end
    check(4'd4, 32'hCAFEF00D, "R9");
    check(4'd5, 32'h1EDC6F41, "R9");
    check(4'd2, 32'h0, "R9");
    @(negedge clk);
    addr = 4'd4; rdEn = 1'b0; #1;
    total++;
    if (rdData !== 32'h0) begin
      bad++;
      $display("FAIL R9 idle actual=%h expected=%h", rdData, 32'h0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule